// File: doc/BRIEF.md
# Accelerator Run-Control Sequencer

This block is the run-control state machine of a small accelerator. A start command moves it from idle into a preparation phase. It stays there until a random seed is reported ready, and then it enters execution. A stop request carries a vector of error bits. In execution, a stop always leads into a timed wipe phase, and the error bits decide whether that wipe ends in idle or in a permanent lock. A separate memory-wipe command gives a timed wipe from idle that returns to idle.

The state register holds numeric codes. Dividing a code by ten gives the coarse status that software sees: 0 idle, 1 busy executing, 2 busy wiping memory, 255 locked. The block also produces:
- a one-cycle done pulse on every stop it accepts;
- a register that accumulates the error bits of the current run;
- a busy-executing flag and a wipe-active flag;
- a pulse that tells the execution unit to clear its program counter;
- a count of the cycles spent in the present state.

Instruction execution, the memories and the clearing of registers are handled elsewhere. The wipe-active flag is the only sign of a wipe that this block gives.

Top module: `accel_run_ctrl`

## Requirements
- R1: After reset the state code is 0 (idle), the status is 0, the error register is 0, and the done pulse, the program-counter clear pulse and both busy flags are low.
- R2: A start in idle, with no fatal stop in the same cycle, moves the state to code 10 at the next edge. In that first cycle of code 10 the program-counter clear pulse is high and the error register is 0.
- R3: Code 10 holds while the seed-ready input is low. The first edge with seed-ready high moves it to code 12 (execute).
- R4: A stop in code 12 goes to code 14 (bad wipe) when the stop is fatal, and to code 13 (good wipe) otherwise. A stop is fatal when any error bit at position 16 or above is set, when bit 10 is set, or when any error bit is set while the software-errors-fatal input is high.
- R5: A wipe entered from code 12 lasts SEC_WIPE_CYC cycles (98) when the secure-wipe enable is high at the stop, and FAST_WIPE_CYC cycles (2) when it is low. A good wipe then ends in code 0, and a bad wipe ends in code 2550.
- R6: A fatal stop during either wipe forces code 14 and does not restart the wipe timer. A non-fatal stop during a wipe is ignored.
- R7: A fatal stop in code 0, 10 or 20 goes straight to code 2550. A non-fatal stop in those states is ignored: the state, the error register and the done pulse are unchanged.
- R8: Every accepted stop raises the done pulse for exactly the one cycle after the edge that took it, and ORs its error bits into the error register.
- R9: The dwell counter is 0 in the first cycle of each state. It rises by one for each further cycle in that state and saturates at its all-ones value.
- R10: The status output equals the state code divided by ten. Busy-executing is high in codes 10, 12, 13 and 14. Wipe-active is high only in codes 13 and 14.
- R11: Code 2550 ignores every input and is left only through reset.
- R12: The memory-wipe command is taken only in code 0, and a start in the same cycle takes priority. Code 20 lasts MEM_WIPE_CYC cycles and then returns to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startCmd | input | 1 | Start-run command |
| memWipeCmd | input | 1 | Memory-wipe command |
| seedReady | input | 1 | Random seed available |
| stopReq | input | 1 | Stop request |
| stopErr | input | ERR_W | Error bits carried by the stop request |
| swErrFatal | input | 1 | Treat any error bit as fatal |
| secWipeEn | input | 1 | Select the long secure wipe |
| stateCode | output | 12 | Numeric state code |
| statusCode | output | 8 | Coarse status (state code / 10) |
| doneIrq | output | 1 | Done pulse after an accepted stop |
| errBits | output | ERR_W | Accumulated error bits |
| busyExec | output | 1 | Run in progress |
| wipeActive | output | 1 | Run-end wipe in progress |
| dwellCnt | output | DWELL_W | Cycles spent in the present state |
| progCntClr | output | 1 | Clear the program counter |

## Verification
The bench builds the block with both wipe lengths at their defaults (98 and 2) and with MEM_WIPE_CYC shortened to 7, so that full secure wipes, fast wipes and memory wipes all fit into dozens of runs. DWELL_W is cut to 6. This brings dwell-counter saturation at 63 within reach during the 98-cycle wipe, and the bench checks that the counter ends on the saturated value there and on 1 in a fast wipe. The error patterns cover the clean stop, low bits alone, bit 10, and upper bits under both settings of the fatal input. They also cover escalation partway through a wipe.

// File: rtl/accel_run_ctrl_pkg.sv
package accel_run_ctrl_pkg;

  typedef enum logic [11:0] {
    ST_IDLE     = 12'd0,
    ST_PREP     = 12'd10,
    ST_RUN      = 12'd12,
    ST_WIPE_OK  = 12'd13,
    ST_WIPE_ERR = 12'd14,
    ST_MEM_WIPE = 12'd20,
    ST_LOCK     = 12'd2550
  } runState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrErr;
    logic mergeErr;
    logic raiseDone;
    logic loadSec;
    logic loadFast;
    logic loadMem;
    logic tmrDec;
    logic stChange;
    logic pcClr;
  } ctrlStrobe_t;

  localparam int LOCK_SINGLE_BIT = 10;
  localparam int LOCK_FIELD_LSB  = 16;

  // fatal-stop decision; error vector zero-extended to 64 bits
  function automatic logic mustLock(input logic [63:0] err, input logic swFatal);
    return (|(err >> LOCK_FIELD_LSB)) || err[LOCK_SINGLE_BIT] || (swFatal && (|err));
  endfunction

  function automatic logic [7:0] statusOf(input runState_e st);
    case (st)
      ST_IDLE:                                    return 8'd0;
      ST_PREP, ST_RUN, ST_WIPE_OK, ST_WIPE_ERR:   return 8'd1;
      ST_MEM_WIPE:                                return 8'd2;
      default:                                    return 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/arc_control.sv
module arc_control
  import accel_run_ctrl_pkg::*;
#(
  parameter int ERR_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCmd,
  input  logic             memWipeCmd,
  input  logic             seedReady,
  input  logic             stopReq,
  input  logic [ERR_W-1:0] stopErr,
  input  logic             swErrFatal,
  input  logic             secWipeEn,
  input  logic             tmrZero,
  output runState_e        stCur,
  output ctrlStrobe_t      strobe,
  output logic             busyExec,
  output logic             wipeActive
);

  runState_e stNext;
  logic      fatalStop;
  logic      toBad;

  assign fatalStop = stopReq && mustLock(64'(stopErr), swErrFatal);
  assign toBad     = (stCur == ST_WIPE_ERR) || fatalStop;

  always_comb begin
    stNext = stCur;
    strobe = '0;
    unique case (stCur)
      ST_IDLE: begin
        if (fatalStop) begin
          stNext           = ST_LOCK;
          strobe.raiseDone = 1'b1;
          strobe.mergeErr  = 1'b1;
        end else if (startCmd) begin
          stNext        = ST_PREP;
          strobe.pcClr  = 1'b1;
          strobe.clrErr = 1'b1;
        end else if (memWipeCmd) begin
          stNext         = ST_MEM_WIPE;
          strobe.loadMem = 1'b1;
        end
      end
      ST_PREP: begin
        if (fatalStop) begin
          stNext           = ST_LOCK;
          strobe.raiseDone = 1'b1;
          strobe.mergeErr  = 1'b1;
        end else if (seedReady) begin
          stNext = ST_RUN;
        end
      end
      ST_RUN: begin
        if (stopReq) begin
          stNext           = fatalStop ? ST_WIPE_ERR : ST_WIPE_OK;
          strobe.raiseDone = 1'b1;
          strobe.mergeErr  = 1'b1;
          strobe.loadSec   = secWipeEn;
          strobe.loadFast  = !secWipeEn;
        end
      end
      ST_WIPE_OK, ST_WIPE_ERR: begin
        if (fatalStop) begin
          strobe.raiseDone = 1'b1;
          strobe.mergeErr  = 1'b1;
        end
        if (tmrZero) begin
          stNext = toBad ? ST_LOCK : ST_IDLE;
        end else begin
          stNext        = toBad ? ST_WIPE_ERR : ST_WIPE_OK;
          strobe.tmrDec = 1'b1;
        end
      end
      ST_MEM_WIPE: begin
        if (fatalStop) begin
          stNext           = ST_LOCK;
          strobe.raiseDone = 1'b1;
          strobe.mergeErr  = 1'b1;
        end else if (tmrZero) begin
          stNext = ST_IDLE;
        end else begin
          strobe.tmrDec = 1'b1;
        end
      end
      ST_LOCK: stNext = ST_LOCK;
      default: stNext = ST_LOCK;
    endcase
    strobe.stChange = (stNext != stCur);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stCur <= ST_IDLE;
    else       stCur <= stNext;
  end

  assign busyExec   = (stCur == ST_PREP) || (stCur == ST_RUN) ||
                      (stCur == ST_WIPE_OK) || (stCur == ST_WIPE_ERR);
  assign wipeActive = (stCur == ST_WIPE_OK) || (stCur == ST_WIPE_ERR);

endmodule

// File: rtl/arc_datapath.sv
module arc_datapath
  import accel_run_ctrl_pkg::*;
#(
  parameter int ERR_W         = 32,
  parameter int SEC_WIPE_CYC  = 98,
  parameter int FAST_WIPE_CYC = 2,
  parameter int MEM_WIPE_CYC  = 64,
  parameter int DWELL_W       = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  runState_e          stCur,
  input  logic [ERR_W-1:0]   stopErr,
  output logic               tmrZero,
  output logic [ERR_W-1:0]   errBits,
  output logic               doneIrq,
  output logic               progCntClr,
  output logic [DWELL_W-1:0] dwellCnt,
  output logic [7:0]         statusCode
);

  localparam int MAX_A   = (SEC_WIPE_CYC > FAST_WIPE_CYC) ? SEC_WIPE_CYC : FAST_WIPE_CYC;
  localparam int MAX_CYC = (MAX_A > MEM_WIPE_CYC) ? MAX_A : MEM_WIPE_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  logic [TMR_W-1:0] tmrLeft;

  // one shared down-counter times every wipe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tmrLeft <= '0;
    else if (strobe.loadSec)  tmrLeft <= TMR_W'(SEC_WIPE_CYC - 1);
    else if (strobe.loadFast) tmrLeft <= TMR_W'(FAST_WIPE_CYC - 1);
    else if (strobe.loadMem)  tmrLeft <= TMR_W'(MEM_WIPE_CYC - 1);
    else if (strobe.tmrDec)   tmrLeft <= tmrLeft - 1'b1;
  end
  assign tmrZero = (tmrLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errBits    <= '0;
      doneIrq    <= 1'b0;
      progCntClr <= 1'b0;
    end else begin
      if (strobe.clrErr)        errBits <= '0;
      else if (strobe.mergeErr) errBits <= errBits | stopErr;
      doneIrq    <= strobe.raiseDone;
      progCntClr <= strobe.pcClr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dwellCnt <= '0;
    else if (strobe.stChange) dwellCnt <= '0;
    else if (!(&dwellCnt))    dwellCnt <= dwellCnt + 1'b1;
  end

  assign statusCode = statusOf(stCur);

endmodule

// File: rtl/accel_run_ctrl.sv
module accel_run_ctrl
  import accel_run_ctrl_pkg::*;
#(
  parameter int ERR_W         = 32,
  parameter int SEC_WIPE_CYC  = 98,
  parameter int FAST_WIPE_CYC = 2,
  parameter int MEM_WIPE_CYC  = 64,
  parameter int DWELL_W       = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startCmd,
  input  logic               memWipeCmd,
  input  logic               seedReady,
  input  logic               stopReq,
  input  logic [ERR_W-1:0]   stopErr,
  input  logic               swErrFatal,
  input  logic               secWipeEn,
  output logic [11:0]        stateCode,
  output logic [7:0]         statusCode,
  output logic               doneIrq,
  output logic [ERR_W-1:0]   errBits,
  output logic               busyExec,
  output logic               wipeActive,
  output logic [DWELL_W-1:0] dwellCnt,
  output logic               progCntClr
);

  runState_e   stCur;
  ctrlStrobe_t strobe;
  logic        tmrZero;

  arc_control #(.ERR_W(ERR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .memWipeCmd(memWipeCmd),
    .seedReady(seedReady), .stopReq(stopReq), .stopErr(stopErr),
    .swErrFatal(swErrFatal), .secWipeEn(secWipeEn), .tmrZero(tmrZero),
    .stCur(stCur), .strobe(strobe), .busyExec(busyExec), .wipeActive(wipeActive)
  );

  arc_datapath #(
    .ERR_W(ERR_W), .SEC_WIPE_CYC(SEC_WIPE_CYC), .FAST_WIPE_CYC(FAST_WIPE_CYC),
    .MEM_WIPE_CYC(MEM_WIPE_CYC), .DWELL_W(DWELL_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stCur(stCur), .stopErr(stopErr),
    .tmrZero(tmrZero), .errBits(errBits), .doneIrq(doneIrq),
    .progCntClr(progCntClr), .dwellCnt(dwellCnt), .statusCode(statusCode)
  );

  assign stateCode = stCur;

endmodule

// File: rtl/accel_run_ctrl_chk.sv
module accel_run_ctrl_chk
  import accel_run_ctrl_pkg::*;
#(
  parameter int ERR_W   = 32,
  parameter int DWELL_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               startCmd,
  input logic               memWipeCmd,
  input logic               seedReady,
  input logic               stopReq,
  input logic [ERR_W-1:0]   stopErr,
  input logic               swErrFatal,
  input logic               secWipeEn,
  input logic [11:0]        stateCode,
  input logic [7:0]         statusCode,
  input logic               doneIrq,
  input logic [ERR_W-1:0]   errBits,
  input logic               busyExec,
  input logic               wipeActive,
  input logic [DWELL_W-1:0] dwellCnt,
  input logic               progCntClr
);

  logic fatalNow;
  assign fatalNow = stopReq && mustLock(64'(stopErr), swErrFatal);

  a_r2_start_prep: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 12'd0 && startCmd && !fatalNow) |=>
      (stateCode == 12'd10 && errBits == '0 && progCntClr));

  a_r3_wait_seed: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 12'd10 && !seedReady && !fatalNow) |=> stateCode == 12'd10);

  a_r4_good_wipe: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 12'd12 && stopReq && !fatalNow) |=> stateCode == 12'd13);

  a_r4_bad_wipe: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 12'd12 && fatalNow) |=> stateCode == 12'd14);

  a_r5_fast_wipe: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 12'd12 && stopReq && !secWipeEn) |=> wipeActive ##1 wipeActive ##1 !wipeActive);

  a_r6_escalate: assert property (@(posedge clk) disable iff (!rstN)
    (wipeActive && fatalNow && stateCode == 12'd13) |=> stateCode inside {12'd14, 12'd2550});

  a_r6_bad_no_recover: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 12'd14) |=> stateCode inside {12'd14, 12'd2550});

  a_r8_done_merge: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> ($past(stopReq) && errBits == ($past(errBits) | $past(stopErr))));

  a_r9_dwell_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode != $past(stateCode)) |-> dwellCnt == '0);

  a_r10_status: assert property (@(posedge clk) disable iff (!rstN)
    (statusCode == 8'(stateCode / 12'd10)) &&
    (busyExec == (stateCode inside {12'd10, 12'd12, 12'd13, 12'd14})) &&
    (wipeActive == (stateCode inside {12'd13, 12'd14})));

  a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 12'd2550) |=> stateCode == 12'd2550);

  a_r12_mem_wipe: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 12'd0 && memWipeCmd && !startCmd && !fatalNow) |=> stateCode == 12'd20);

endmodule

bind accel_run_ctrl accel_run_ctrl_chk #(.ERR_W(ERR_W), .DWELL_W(DWELL_W)) uChk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .memWipeCmd(memWipeCmd),
  .seedReady(seedReady), .stopReq(stopReq), .stopErr(stopErr),
  .swErrFatal(swErrFatal), .secWipeEn(secWipeEn), .stateCode(stateCode),
  .statusCode(statusCode), .doneIrq(doneIrq), .errBits(errBits),
  .busyExec(busyExec), .wipeActive(wipeActive), .dwellCnt(dwellCnt),
  .progCntClr(progCntClr)
);

// File: tb/accel_run_ctrl_test.sv
`timescale 1ns/1ps
module accel_run_ctrl_test;

  localparam int ERR_W   = 32;
  localparam int SEC_CYC = 98;
  localparam int FST_CYC = 2;
  localparam int MEM_CYC = 7;
  localparam int DW_W    = 6;
  localparam int DW_MAX  = (1 << DW_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startCmd = 1'b0, memWipeCmd = 1'b0, seedReady = 1'b0, stopReq = 1'b0;
  logic [ERR_W-1:0] stopErr = '0;
  logic swErrFatal = 1'b0, secWipeEn = 1'b0;
  logic [11:0] stateCode;
  logic [7:0] statusCode;
  logic doneIrq, busyExec, wipeActive, progCntClr;
  logic [ERR_W-1:0] errBits;
  logic [DW_W-1:0] dwellCnt;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  accel_run_ctrl #(.ERR_W(ERR_W), .SEC_WIPE_CYC(SEC_CYC), .FAST_WIPE_CYC(FST_CYC),
                   .MEM_WIPE_CYC(MEM_CYC), .DWELL_W(DW_W)) uut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .memWipeCmd(memWipeCmd),
    .seedReady(seedReady), .stopReq(stopReq), .stopErr(stopErr),
    .swErrFatal(swErrFatal), .secWipeEn(secWipeEn), .stateCode(stateCode),
    .statusCode(statusCode), .doneIrq(doneIrq), .errBits(errBits),
    .busyExec(busyExec), .wipeActive(wipeActive), .dwellCnt(dwellCnt),
    .progCntClr(progCntClr)
  );

  function automatic bit expLock(input logic [31:0] err, input bit fat);
    return (err[31:16] != 0) || err[10] || (fat && err != 0);
  endfunction

  function automatic int expStatus(input int code);
    return code / 10;
  endfunction

  function automatic bit expBusy(input int code);
    return code == 10 || code == 12 || code == 13 || code == 14;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input int code);
    chk({tag, " state"}, stateCode, code);
    chk("R10 status", statusCode, expStatus(code));
    chk("R10 busyExec", busyExec, expBusy(code));
    chk("R10 wipeActive", wipeActive, (code == 13 || code == 14));
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0;
    startCmd = 0; memWipeCmd = 0; seedReady = 0; stopReq = 0; stopErr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step;
  endtask

  task automatic finishRun;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // count remaining wipe samples (first one already observed)
  task automatic countWipe(output int n, output int lastDwell);
    n = 1;
    lastDwell = int'(dwellCnt);
    for (int g = 0; g < 400; g++) begin
      step;
      if (!wipeActive) break;
      n++;
      lastDwell = int'(dwellCnt);
    end
  endtask

  task automatic runJob(input logic [31:0] err, input bit fat, input bit sec,
                        input int seedDly, input int runDly);
    bit lk;
    int wl;
    int n;
    int lastDw;
    lk = expLock(err, fat);
    wl = sec ? SEC_CYC : FST_CYC;
    swErrFatal = fat; secWipeEn = sec;
    startCmd = 1; step; startCmd = 0;
    chkState("R2", 10);
    chk("R2 progCntClr", progCntClr, 1);
    chk("R2 errBits cleared", errBits, 0);
    chk("R9 dwell on entry", dwellCnt, 0);
    for (int i = 0; i < seedDly; i++) begin
      step;
      chk("R3 hold", stateCode, 10);
    end
    chk("R9 dwell count", dwellCnt, seedDly);
    seedReady = 1; step; seedReady = 0;
    chkState("R3", 12);
    for (int i = 0; i < runDly; i++) step;
    stopReq = 1; stopErr = err; step; stopReq = 0; stopErr = '0;
    chkState("R4", lk ? 14 : 13);
    chk("R8 doneIrq", doneIrq, 1);
    chk("R8 errBits", errBits, err);
    countWipe(n, lastDw);
    chk("R5 wipe length", n, wl);
    chk("R9 dwell at wipe end", lastDw, (wl - 1 > DW_MAX) ? DW_MAX : wl - 1);
    chkState("R5 end", lk ? 2550 : 0);
    chk("R8 done single", doneIrq, 0);
    if (lk) begin
      startCmd = 1; memWipeCmd = 1; step; startCmd = 0; memWipeCmd = 0;
      chk("R11 locked", stateCode, 2550);
      doReset;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    finishRun;
  end

  initial begin
    int n;
    int lastDw;
    void'($urandom(32'd2024));
    doReset;
    // R1 reset state
    chkState("R1", 0);
    chk("R1 errBits", errBits, 0);
    chk("R1 doneIrq", doneIrq, 0);
    chk("R1 progCntClr", progCntClr, 0);

    // R9 saturation in idle
    repeat (DW_MAX + 10) step;
    chk("R9 saturate", dwellCnt, DW_MAX);

    // R12 memory wipe
    memWipeCmd = 1; step; memWipeCmd = 0;
    chkState("R12", 20);
    n = 1;
    for (int g = 0; g < 50; g++) begin
      step;
      if (stateCode != 20) break;
      n++;
    end
    chk("R12 mem wipe length", n, MEM_CYC);
    chkState("R12 back", 0);

    // R12 start wins over memory wipe; memory wipe ignored in prep
    startCmd = 1; memWipeCmd = 1; step; startCmd = 0;
    chk("R12 start priority", stateCode, 10);
    step; memWipeCmd = 0;
    chk("R12 ignored outside idle", stateCode, 10);
    // R7 fatal stop in prep locks
    swErrFatal = 0;
    stopReq = 1; stopErr = 32'h0000_0400; step; stopReq = 0; stopErr = '0;
    chkState("R7 prep fatal", 2550);
    chk("R8 doneIrq prep", doneIrq, 1);
    chk("R8 errBits prep", errBits, 32'h400);
    doReset;

    // R7 non-fatal stop in idle ignored
    stopReq = 1; stopErr = 32'h0000_0021; step; stopReq = 0; stopErr = '0;
    chkState("R7 idle ignore", 0);
    chk("R7 no done", doneIrq, 0);
    chk("R7 errBits kept", errBits, 0);
    // R7 fatal stop in idle
    stopReq = 1; stopErr = 32'h0010_0000; step; stopReq = 0; stopErr = '0;
    chkState("R7 idle fatal", 2550);
    chk("R8 errBits idle", errBits, 32'h0010_0000);
    doReset;

    // R6 ignore then escalate during a secure good wipe
    swErrFatal = 0; secWipeEn = 1;
    startCmd = 1; step; startCmd = 0;
    seedReady = 1; step; seedReady = 0;
    stopReq = 1; stopErr = 32'h2; step; stopReq = 0; stopErr = '0;
    chkState("R4 good", 13);
    repeat (3) step;
    stopReq = 1; stopErr = 32'h4; step; stopReq = 0; stopErr = '0;
    chk("R6 non-fatal ignored", stateCode, 13);
    chk("R6 errBits unchanged", errBits, 32'h2);
    chk("R6 no done", doneIrq, 0);
    stopReq = 1; stopErr = 32'h400; step; stopReq = 0; stopErr = '0;
    chkState("R6 escalated", 14);
    chk("R6 errBits merged", errBits, 32'h402);
    chk("R8 done on escalation", doneIrq, 1);
    countWipe(n, lastDw);
    chk("R6 timer not restarted", n + 5, SEC_CYC);
    chkState("R6 lock", 2550);
    doReset;

    // directed corner jobs
    runJob(32'h0, 1'b1, 1'b0, 0, 0);         // R4 clean stop, fatal strap, no bits
    runJob(32'h0000_0001, 1'b1, 1'b0, 2, 1); // R4 strap makes low bit fatal
    runJob(32'h0000_8000, 1'b0, 1'b1, 1, 0); // R4 bit 15 alone not fatal
    runJob(32'h0001_0000, 1'b0, 1'b0, 3, 2); // R4 bit 16 fatal

    // constrained random jobs
    for (int j = 0; j < 30; j++) begin
      logic [31:0] e;
      int sel;
      int b;
      sel = int'($urandom % 4);
      b = int'($urandom % 15);
      if (b >= 10) b++;
      case (sel)
        0: e = 32'h0;
        1: e = 32'h1 << b;
        2: e = (32'h1 << 10) | (32'h1 << (b % 10));
        default: e = 32'h1 << (16 + int'($urandom % 16));
      endcase
      runJob(e, bit'($urandom % 2), ($urandom % 4) == 0,
             int'($urandom % 5), int'($urandom % 4));
    end

    finishRun;
  end

endmodule